// File: doc/BRIEF.md
# Thermistor Resistance Tracker with Thermal Protection

This block turns the resistance of an external thermistor into an 8-bit temperature code by closing a slow digital loop around a current-output DAC and one comparator. The DAC drives a current proportional to the code (full scale about 80 µA) into the thermistor pin. The comparator reports whether the pin voltage sits above the 1.25 V reference. Each time the loop is paced, the code moves by one LSB toward balance. At balance the code is roughly 4 MΩ divided by the thermistor plus series resistance, so a larger code means a hotter thermistor.

After reset the loop runs in a fast phase, stepping every few clock cycles so that the code has settled well within a few milliseconds. The converter stages stay disabled until that phase ends and the filtered code reads cooler than the 110 °C threshold. In normal operation the loop steps only on every seventh half line-cycle strobe. A short shift-based low-pass filter produces the temperature code. That code drives a self-clearing overtemperature shutdown with hysteresis: it trips near 130 °C and releases below 110 °C. A second, very slow filter drives a linear derating factor that scales the dimming level: full level at 95 °C or below, half level at 125 °C or above.

Top module: `ntc_track`

## Requirements
- R1: While reset is high and on the first cycle after it: dac_code is 0, track_fast is 1, stage_en is 0, ot_shutdown is 0, derate_q8 is 256 and dim_out is 0.
- R2: In the fast phase the code takes one step every FAST_DIV clock cycles. After 2^CODE_W such steps (4096 cycles with default settings) track_fast falls, and it never rises again until reset.
- R3: Outside the fast phase the code changes only on every HALF_DIV-th (7th) half_cycle strobe, and then by exactly one LSB. It moves down when cmp_above is 1 and up when cmp_above is 0.
- R4: The code saturates. It stays at 0 when the comparator reports high at code 0, and it stays at 255 when the comparator reports low at code 255.
- R5: stage_en stays 0 through the fast phase and until temp_code first reads below CODE_WARN (128). From then on stage_en equals the inverse of ot_shutdown.
- R6: ot_shutdown rises only when temp_code is at or above CODE_SHUT (176). Once set it clears only when temp_code falls below CODE_WARN (128). The code keeps tracking while the shutdown is active.
- R7: derate_q8 is a Q8 factor computed from the slow-filtered code s. It is 256 for s ≤ CODE_DERATE_LO (96) and 128 for s ≥ CODE_DERATE_HI (160). In between it is 256 − floor((s − 96)·128 / 64).
- R8: dim_out equals floor(dim_in · derate_q8 / 256).
- R9: temp_code is a shift-based low-pass filter of dac_code. For a held code it settles to exactly that code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_cycle | input | 1 | One-cycle pulse per rectified half line-cycle |
| cmp_above | input | 1 | Comparator result: 1 when the thermistor pin is above the reference |
| dim_in | input | DIM_W | Dimming level before derating |
| dac_code | output | CODE_W | Code driving the current DAC |
| track_fast | output | 1 | 1 during the startup fast-tracking phase |
| temp_code | output | CODE_W | Fast-filtered temperature code |
| stage_en | output | 1 | Permission to run the boost and second stages |
| ot_shutdown | output | 1 | Overtemperature shutdown active |
| derate_q8 | output | 9 | Thermal derating factor, 256 means 100 % |
| dim_out | output | DIM_W | Derated dimming level |

## Verification
The properties assume that half_cycle is a single-cycle pulse and that cmp_above is a function of the current dac_code, as a real DAC and comparator would make it. The bench models the thermistor as a balance code, with a comparator that reports high whenever the code exceeds that balance. Strobes are spaced about twenty cycles apart, so that the temperature filter settles between steps. A force input pins the comparator high to exercise the lower bound, and an unreachable balance exercises the upper bound.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  typedef enum logic {
    PH_FAST = 1'b0,
    PH_SLOW = 1'b1
  } track_phase_t;

  localparam int FACTOR_W    = 9;
  localparam int FACTOR_FULL = 256;
  localparam int FACTOR_HALF = 128;
endpackage

// File: rtl/ntc_stepper.sv
module ntc_stepper #(
  parameter int CODE_W   = 8,
  parameter int FAST_DIV = 16,
  parameter int HALF_DIV = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              half_cycle,
  input  logic              cmp_above,
  output logic [CODE_W-1:0] code,
  output logic              fast
);
  import ntc_pkg::*;

  localparam int FC_W  = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam int HC_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int SC_W  = CODE_W + 1;
  localparam int STEPS = 2 ** CODE_W;
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  track_phase_t    phase;
  logic [FC_W-1:0] fast_cnt;
  logic [HC_W-1:0] hc_cnt;
  logic [SC_W-1:0] step_cnt;
  logic            tick;
  logic [CODE_W-1:0] code_n;

  always_comb begin
    if (phase == PH_FAST) tick = (fast_cnt == FC_W'(FAST_DIV - 1));
    else                  tick = half_cycle && (hc_cnt == HC_W'(HALF_DIV - 1));
  end

  always_comb begin
    code_n = code;
    if (tick) begin
      if (cmp_above) code_n = (code == '0) ? code : code - 1'b1;
      else           code_n = (code == CODE_MAX) ? code : code + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_FAST;
      fast_cnt <= '0;
      hc_cnt   <= '0;
      step_cnt <= '0;
      code     <= '0;
    end else begin
      code <= code_n;
      if (phase == PH_FAST) begin
        fast_cnt <= tick ? '0 : fast_cnt + 1'b1;
        if (tick) begin
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == SC_W'(STEPS - 1)) phase <= PH_SLOW;
        end
      end else if (half_cycle) begin
        hc_cnt <= tick ? '0 : hc_cnt + 1'b1;
      end
    end
  end

  assign fast = (phase == PH_FAST);
endmodule

// File: rtl/ntc_iir.sv
module ntc_iir #(
  parameter int W  = 8,
  parameter int SH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (SH == 0) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst)     dout <= '0;
        else if (en) dout <= din;
      end
    end else begin : g_filt
      localparam int AW = W + SH;
      logic [AW-1:0] acc;
      always_ff @(posedge clk) begin
        if (rst)     acc <= '0;
        else if (en) acc <= acc - (acc >> SH) + AW'(din);
      end
      assign dout = W'(acc >> SH);
    end
  endgenerate
endmodule

// File: rtl/ntc_guard.sv
module ntc_guard #(
  parameter int CODE_W    = 8,
  parameter int CODE_WARN = 128,
  parameter int CODE_SHUT = 176
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fast,
  input  logic [CODE_W-1:0] temp,
  output logic              shutdown,
  output logic              stage_en
);
  logic gate_ok;
  logic cool;
  logic hot;
  logic gate_n;
  logic shut_n;

  assign cool   = (temp <  CODE_W'(CODE_WARN));
  assign hot    = (temp >= CODE_W'(CODE_SHUT));
  assign gate_n = gate_ok || (!fast && cool);
  assign shut_n = shutdown ? !cool : hot;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_ok  <= 1'b0;
      shutdown <= 1'b0;
      stage_en <= 1'b0;
    end else begin
      gate_ok  <= gate_n;
      shutdown <= shut_n;
      stage_en <= gate_n && !shut_n;
    end
  end
endmodule

// File: rtl/ntc_derate.sv
module ntc_derate #(
  parameter int CODE_W         = 8,
  parameter int DIM_W          = 10,
  parameter int CODE_DERATE_LO = 96,
  parameter int CODE_DERATE_HI = 160
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [CODE_W-1:0]             slow_temp,
  input  logic [DIM_W-1:0]              dim_in,
  output logic [ntc_pkg::FACTOR_W-1:0]  factor,
  output logic [DIM_W-1:0]              dim_out
);
  import ntc_pkg::*;

  localparam int SPAN = CODE_DERATE_HI - CODE_DERATE_LO;
  localparam int PW   = DIM_W + FACTOR_W;

  logic [31:0]         drop;
  logic [FACTOR_W-1:0] factor_n;
  logic [PW-1:0]       prod;

  always_comb begin
    drop = (32'(slow_temp - CODE_W'(CODE_DERATE_LO)) << 7) / 32'(SPAN);
    if (slow_temp <= CODE_W'(CODE_DERATE_LO))      factor_n = FACTOR_W'(FACTOR_FULL);
    else if (slow_temp >= CODE_W'(CODE_DERATE_HI)) factor_n = FACTOR_W'(FACTOR_HALF);
    else factor_n = FACTOR_W'(32'(FACTOR_FULL) - drop);
  end

  assign prod = PW'(dim_in) * PW'(factor);

  always_ff @(posedge clk) begin
    if (rst) begin
      factor  <= FACTOR_W'(FACTOR_FULL);
      dim_out <= '0;
    end else begin
      factor  <= factor_n;
      dim_out <= DIM_W'(prod >> 8);
    end
  end
endmodule

// File: rtl/ntc_track.sv
module ntc_track #(
  parameter int CODE_W         = 8,
  parameter int DIM_W          = 10,
  parameter int FAST_DIV       = 16,
  parameter int HALF_DIV       = 7,
  parameter int FAST_SHIFT     = 3,
  parameter int SLOW_SHIFT     = 14,
  parameter int CODE_DERATE_LO = 96,
  parameter int CODE_WARN      = 128,
  parameter int CODE_DERATE_HI = 160,
  parameter int CODE_SHUT      = 176
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         half_cycle,
  input  logic                         cmp_above,
  input  logic [DIM_W-1:0]             dim_in,
  output logic [CODE_W-1:0]            dac_code,
  output logic                         track_fast,
  output logic [CODE_W-1:0]            temp_code,
  output logic                         stage_en,
  output logic                         ot_shutdown,
  output logic [ntc_pkg::FACTOR_W-1:0] derate_q8,
  output logic [DIM_W-1:0]             dim_out
);
  logic [CODE_W-1:0] slow_temp;

  ntc_stepper #(.CODE_W(CODE_W), .FAST_DIV(FAST_DIV), .HALF_DIV(HALF_DIV)) u_step (
    .clk(clk), .rst(rst), .half_cycle(half_cycle), .cmp_above(cmp_above),
    .code(dac_code), .fast(track_fast)
  );

  ntc_iir #(.W(CODE_W), .SH(FAST_SHIFT)) u_fast_lpf (
    .clk(clk), .rst(rst), .en(1'b1), .din(dac_code), .dout(temp_code)
  );

  ntc_iir #(.W(CODE_W), .SH(SLOW_SHIFT)) u_slow_lpf (
    .clk(clk), .rst(rst), .en(half_cycle), .din(temp_code), .dout(slow_temp)
  );

  ntc_guard #(.CODE_W(CODE_W), .CODE_WARN(CODE_WARN), .CODE_SHUT(CODE_SHUT)) u_guard (
    .clk(clk), .rst(rst), .fast(track_fast), .temp(temp_code),
    .shutdown(ot_shutdown), .stage_en(stage_en)
  );

  ntc_derate #(.CODE_W(CODE_W), .DIM_W(DIM_W),
               .CODE_DERATE_LO(CODE_DERATE_LO), .CODE_DERATE_HI(CODE_DERATE_HI)) u_derate (
    .clk(clk), .rst(rst), .slow_temp(slow_temp), .dim_in(dim_in),
    .factor(derate_q8), .dim_out(dim_out)
  );
endmodule

// File: rtl/ntc_track_chk.sv
module ntc_track_chk #(
  parameter int CODE_W    = 8,
  parameter int CODE_WARN = 128,
  parameter int CODE_SHUT = 176
) (
  input logic              clk,
  input logic              rst,
  input logic              half_cycle,
  input logic [CODE_W-1:0] dac_code,
  input logic              track_fast,
  input logic [CODE_W-1:0] temp_code,
  input logic              stage_en,
  input logic              ot_shutdown,
  input logic [8:0]        derate_q8
);
  // R3/R4: one LSB at most per cycle, never a wrap
  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, dac_code} == {1'b0, $past(dac_code)}) ||
    ({1'b0, dac_code} == {1'b0, $past(dac_code)} + 1'b1) ||
    ({1'b0, dac_code} + 1'b1 == {1'b0, $past(dac_code)}));

  // R3: in the slow phase the code moves only after a strobe
  assert_paced_by_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (!track_fast && !$past(track_fast) && dac_code != $past(dac_code)) |-> $past(half_cycle));

  // R2: the fast phase never restarts
  assert_fast_once_R2: assert property (@(posedge clk) disable iff (rst)
    !$rose(track_fast));

  // R6: trip and release thresholds
  assert_trip_level_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ot_shutdown) |-> ($past(temp_code) >= CODE_W'(CODE_SHUT)));
  assert_release_level_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ot_shutdown) |-> ($past(temp_code) < CODE_W'(CODE_WARN)));

  // R5: stages run only after startup and never during shutdown
  assert_enable_gate_R5: assert property (@(posedge clk) disable iff (rst)
    stage_en |-> (!ot_shutdown && !track_fast));

  // R7: factor stays within half and full scale
  assert_factor_range_R7: assert property (@(posedge clk) disable iff (rst)
    (derate_q8 >= 9'd128) && (derate_q8 <= 9'd256));
endmodule

bind ntc_track ntc_track_chk #(
  .CODE_W(CODE_W), .CODE_WARN(CODE_WARN), .CODE_SHUT(CODE_SHUT)
) u_chk (
  .clk(clk), .rst(rst), .half_cycle(half_cycle), .dac_code(dac_code),
  .track_fast(track_fast), .temp_code(temp_code), .stage_en(stage_en),
  .ot_shutdown(ot_shutdown), .derate_q8(derate_q8)
);

// File: tb/ntc_track_test.sv
module ntc_track_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       half_cycle = 1'b0;
  logic       cmp_above;
  logic [9:0] dim_in = 10'd1000;
  logic [7:0] dac_code;
  logic       track_fast;
  logic [7:0] temp_code;
  logic       stage_en;
  logic       ot_shutdown;
  logic [8:0] derate_q8;
  logic [9:0] dim_out;

  int  target = 60;
  bit  force_above = 1'b0;
  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  assign cmp_above = force_above ? 1'b1 : (int'(dac_code) > target);

  ntc_track #(.SLOW_SHIFT(4)) uut (
    .clk(clk), .rst(rst), .half_cycle(half_cycle), .cmp_above(cmp_above),
    .dim_in(dim_in), .dac_code(dac_code), .track_fast(track_fast),
    .temp_code(temp_code), .stage_en(stage_en), .ot_shutdown(ot_shutdown),
    .derate_q8(derate_q8), .dim_out(dim_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) half_cycle = 1'b1;
    @(negedge clk) half_cycle = 1'b0;
    repeat (18) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(dac_code == 0 && track_fast && !stage_en && !ot_shutdown, "R1 flags", dac_code, 0);
    check(derate_q8 == 256 && dim_out == 0, "R1 derate", derate_q8, 256);
  endtask

  task automatic t_startup();
    int n = 0;
    force_above = 1'b1;
    target = 60;
    rst = 1'b0;
    repeat (200) @(negedge clk);
    n = 200;
    check(dac_code == 0, "R4 low bound", dac_code, 0);
    check(!stage_en, "R5 gated in fast phase", stage_en, 0);
    force_above = 1'b0;
    while (track_fast && n < 5000) begin @(negedge clk); n++; end
    check(n >= 4094 && n <= 4098, "R2 fast phase length", n, 4096);
    check(dac_code == 60 || dac_code == 61, "R2 settled code", dac_code, 60);
    repeat (40) @(negedge clk);
    check(temp_code == dac_code, "R9 filter settles", temp_code, dac_code);
    check(stage_en && !ot_shutdown, "R5 enable after cool start", stage_en, 1);
  endtask

  task automatic t_slow_steps();
    int c0;
    target = 120;
    c0 = dac_code;
    repeat (6) strobe();
    check(dac_code == c0, "R3 no step before 7th strobe", dac_code, c0);
    strobe();
    check(dac_code == c0 + 1, "R3 step up", dac_code, c0 + 1);
    repeat (7) strobe();
    check(dac_code == c0 + 2, "R3 second step up", dac_code, c0 + 2);
    target = 20;
    repeat (6) strobe();
    check(dac_code == c0 + 2, "R3 hold", dac_code, c0 + 2);
    strobe();
    check(dac_code == c0 + 1, "R3 step down", dac_code, c0 + 1);
  endtask

  task automatic t_hysteresis();
    int  n = 0;
    int  trip_temp = -1;
    int  rel_temp = 999;
    bit  early = 1'b0;
    target = 200;
    while (!ot_shutdown && n < 2000) begin
      if (temp_code < 176 && ot_shutdown) early = 1'b1;
      strobe(); n++;
    end
    trip_temp = temp_code;
    check(ot_shutdown && trip_temp >= 176 && !early, "R6 trip level", trip_temp, 176);
    check(!stage_en, "R5 stages off in shutdown", stage_en, 0);
    repeat (300) strobe();
    check(dac_code >= 199 && dac_code <= 201, "R6 tracking continues", dac_code, 200);
    check(derate_q8 == 128, "R7 hot factor", derate_q8, 128);
    check(dim_out == 500, "R8 half dimming", dim_out, 500);
    target = 140;
    repeat (500) strobe();
    check(ot_shutdown && temp_code >= 139 && temp_code <= 141, "R6 held inside band", temp_code, 140);
    target = 100;
    n = 0;
    while (ot_shutdown && n < 2000) begin strobe(); n++; end
    rel_temp = temp_code;
    check(!ot_shutdown && rel_temp < 128, "R6 release level", rel_temp, 127);
    check(stage_en, "R5 re-enable after release", stage_en, 1);
  endtask

  task automatic t_derate();
    target = 128;
    repeat (350) strobe();
    check(derate_q8 >= 190 && derate_q8 <= 192, "R7 linear midpoint", derate_q8, 192);
    check(dim_out == (1000 * derate_q8) / 256, "R8 scaled dimming", dim_out, (1000 * derate_q8) / 256);
    target = 70;
    dim_in = 10'd777;
    repeat (300) strobe();
    check(derate_q8 == 256, "R7 cool factor", derate_q8, 256);
    check(dim_out == 777, "R8 full dimming", dim_out, 777);
  endtask

  task automatic t_shorted();
    int n = 0;
    target = 999;
    do_reset();
    while (track_fast && n < 5000) begin @(negedge clk); n++; end
    repeat (60) @(negedge clk);
    check(dac_code == 255, "R4 high bound", dac_code, 255);
    check(ot_shutdown && !stage_en, "R5 hot start stays disabled", stage_en, 0);
  endtask

  initial begin
    t_reset_state();
    t_startup();
    t_slow_steps();
    t_hysteresis();
    t_derate();
    t_shorted();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule